// File: doc/BRIEF.md
# Software-Triggered DMA Burst Request Limiter

This block generates the DMA request line of an 8-bit ISA peripheral card. It does not pass through a request from the attached drive; the drive's own request is left unused. Software starts a burst by writing to one decoded IO port, and the block raises its request at once. The value written does not matter, and the block has no data input at all.

While the request is up, the block counts the completed acknowledged transfers. It drops the request by itself after a fixed burst of 16 bytes. At 4 bus cycles per byte, a 72-cycle (15 µs) refresh window holds at most 18 bytes, so a 16-byte burst leaves room for the DMA controller to hand the bus back for memory refresh. Software repeats the port write once for each burst.

The request leaves the card through a three-state driver. While the DMA feature is enabled, the block drives the line at all times, low as well as high, because the bus line has no pull-up. While the feature is disabled, the line floats, so another adapter can use the same channel.

Top module: `dma_burst_gate`

## Requirements
- R1: After reset, the request `drq` is low and the burst counter is zero. With `dma_en` high, the pin `drq_pin` then drives 0.
- R2: With `dma_en` high and `drq` low, the start of a write strobe (`iow_n` going from 1 to 0) while `aen` is 0 and `io_addr` equals `PORT_ADDR` sets `drq` on that clock edge. The same strobe at any other address leaves `drq` low.
- R3: A write strobe while `aen` is 1 never raises `drq`, whatever the address.
- R4: A transfer completes on the first cycle `dack_n` is 1 after a cycle in which `dack_n` was 0 and at least one of `ior_n` and `iow_n` was 0. `drq` clears on the edge that completes the 16th transfer (the counter wraps from 15) and stays high through the first 15.
- R5: A `dack_n` pulse during which neither `ior_n` nor `iow_n` was low does not count as a transfer.
- R6: A port write while `drq` is high is ignored. The burst still ends after 16 transfers counted from the write that started it.
- R7: While `dma_en` is 1, `drq_oe` is 1 and `drq_pin` drives the value of `drq`, both 0 and 1. While `dma_en` is 0, `drq_oe` is 0 and `drq_pin` is high-impedance.
- R8: While `dma_en` is 0, port writes do not raise `drq`. Clearing `dma_en` during a burst drops `drq` and zeroes the counter on the next edge.
- R9: After a burst ends, a new port write starts a full new burst of 16 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | ISA IO address |
| iow_n | input | 1 | IO write strobe, active low |
| ior_n | input | 1 | IO read strobe, active low |
| aen | input | 1 | Address enable, high during DMA cycles |
| dack_n | input | 1 | DMA acknowledge for this channel, active low |
| dma_en | input | 1 | DMA feature enable |
| drq | output | 1 | Internal request state |
| drq_oe | output | 1 | Output enable of the three-state driver |
| drq_pin | output | 1 | Request line to the bus; high-impedance when disabled |

## Verification
The assertions check on every cycle the conditions that can hold at all times. The counter rests at zero whenever no burst is open. A rising request always follows a decoded port write with `aen` low. A falling request always follows a counter at 15 or a disable. The counter never moves by more than one step, and no request can be raised while `aen` is high or the feature is off.

Some behaviours only the bench scenarios can show. These are the exact burst length of 16, the full address sweep with `aen` both low and high, strobe-less acknowledge pulses that are not counted, a retrigger write in the middle of a burst, back-to-back bursts, and the driven-versus-floating states of the pin.

// File: rtl/dma_burst_gate.sv
module dma_burst_gate #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 10'h3A4,
  parameter int BURST_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iow_n,
  input  logic              ior_n,
  input  logic              aen,
  input  logic              dack_n,
  input  logic              dma_en,
  output logic              drq,
  output logic              drq_oe,
  output logic              drq_pin
);
  // BURST_LEN must stay at or below 18 to fit a refresh window.
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic iow_prev, dack_prev, strb_prev;

  wire strb_now = ~ior_n | ~iow_n;
  wire port_hit = ~aen & (io_addr == PORT_ADDR) & ~iow_n & iow_prev;
  wire xfer_end = dack_prev & strb_prev & dack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iow_prev  <= 1'b1;
      dack_prev <= 1'b0;
      strb_prev <= 1'b0;
    end else begin
      iow_prev  <= iow_n;
      dack_prev <= ~dack_n;
      strb_prev <= strb_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dma_en) begin
      drq <= 1'b0;
      cnt <= '0;
    end else if (!drq) begin
      cnt <= '0;
      if (port_hit) drq <= 1'b1;
    end else if (xfer_end) begin
      if (cnt == LAST) begin
        drq <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign drq_oe  = dma_en;
  assign drq_pin = drq_oe ? drq : 1'bz;

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !drq |-> cnt == '0); // R1
  AST_RISE_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(!aen && io_addr == PORT_ADDR && !iow_n && dma_en)); // R2
  AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (!drq && aen) |=> !drq); // R3
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> ($past(cnt) == LAST || !$past(dma_en))); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    drq |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0)); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !dma_en |=> !drq); // R8
endmodule

// File: tb/dma_burst_gate_tb_top.sv
module dma_burst_gate_tb_top;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] PORT = 10'h3A4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic iow_n = 1'b1, ior_n = 1'b1, aen = 1'b0, dack_n = 1'b1, dma_en = 1'b1;
  logic drq, drq_oe, drq_pin;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  dma_burst_gate #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT), .BURST_LEN(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iow_n(iow_n), .ior_n(ior_n),
    .aen(aen), .dack_n(dack_n), .dma_en(dma_en),
    .drq(drq), .drq_oe(drq_oe), .drq_pin(drq_pin));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic [ADDR_W-1:0] a, input logic en_aen);
    @(negedge clk); io_addr = a; aen = en_aen; iow_n = 1'b0;
    @(negedge clk); iow_n = 1'b1;
    @(negedge clk); aen = 1'b0;
  endtask

  task automatic xfer(input bit with_strobe);
    @(negedge clk); aen = 1'b1; dack_n = 1'b0; ior_n = with_strobe ? 1'b0 : 1'b1;
    @(negedge clk);
    @(negedge clk); dack_n = 1'b1; ior_n = 1'b1;
    @(negedge clk); aen = 1'b0;
  endtask

  task automatic burst(input string req, input int first);
    for (int i = first; i < 16; i++) begin
      xfer(1'b1);
      chk(req, {1'b0, drq}, {1'b0, i < 15});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {drq, drq_pin}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {drq, drq_pin}, 2'b00);
    chk("R7", {drq_oe, 1'b0}, 2'b10);

    // R3: full sweep with aen high, never raises
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      port_wr(a[ADDR_W-1:0], 1'b1);
      if (drq !== 1'b0) chk("R3", {1'b0, drq}, 2'b00);
    end
    chk("R3", {1'b0, drq}, 2'b00);

    // R2: full sweep with aen low; only PORT raises, then burst
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      port_wr(a[ADDR_W-1:0], 1'b0);
      if (a[ADDR_W-1:0] == PORT) begin
        chk("R2", {1'b0, drq}, 2'b01);
        chk("R7", {drq_oe, drq_pin}, 2'b11);
        burst("R4", 0);
        chk("R7", {drq_oe, drq_pin}, 2'b10);
      end else if (drq !== 1'b0) chk("R2", {1'b0, drq}, 2'b00);
    end

    // R2 timing: drq visible one cycle after strobe start
    @(negedge clk); io_addr = PORT; iow_n = 1'b0;
    @(negedge clk); chk("R2", {1'b0, drq}, 2'b01);
    iow_n = 1'b1;
    // R5: strobe-less acknowledges do not count
    for (int k = 0; k < 20; k++) xfer(1'b0);
    chk("R5", {1'b0, drq}, 2'b01);
    burst("R5", 0);

    // R6: retrigger mid-burst ignored
    port_wr(PORT, 1'b0);
    for (int i = 0; i < 8; i++) xfer(1'b1);
    port_wr(PORT, 1'b0);
    chk("R6", {1'b0, drq}, 2'b01);
    burst("R6", 8);

    // R9: back-to-back bursts
    for (int b = 0; b < 3; b++) begin
      port_wr(PORT, 1'b0);
      chk("R9", {1'b0, drq}, 2'b01);
      burst("R9", 0);
    end

    // R8: disable during burst, and writes while disabled
    port_wr(PORT, 1'b0);
    for (int i = 0; i < 5; i++) xfer(1'b1);
    @(negedge clk); dma_en = 1'b0;
    @(negedge clk);
    chk("R8", {1'b0, drq}, 2'b00);
    chk("R7", {drq_oe, drq_pin === 1'bz}, 2'b01);
    port_wr(PORT, 1'b0);
    chk("R8", {1'b0, drq}, 2'b00);
    @(negedge clk); dma_en = 1'b1;
    port_wr(PORT, 1'b0);
    chk("R8", {1'b0, drq}, 2'b01);
    burst("R8", 0);

    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule